// File: doc/BRIEF.md
# Immediate-Add and Word Load/Store Execution Unit

This unit executes three immediate-form operations against a 64-bit, 32-entry register file that it holds itself. The operations are add-immediate, load word with zero fill, and store word. Each operation arrives as a 32-bit instruction word together with a 2-bit operation code. The unit pulls three fields from the word: a target/source register index, a base register index and a signed 16-bit immediate. It sign-extends the immediate to 64 bits and adds it to the base value. The base value is the literal zero when the base index is 0, and otherwise the contents of the named register.

For add-immediate, the sum is written to the target register. For loads and stores, the sum is the effective address. The unit issues a single 4-byte memory access on a valid/ready request channel. A load waits for a response that carries the data. A store completes when its request is accepted. Every register write the unit performs is reported for one cycle on a write-back output. A separate fill port lets neighbouring logic write registers directly.

Operation codes: 0 = add-immediate, 1 = load word, 2 = store word, 3 = no operation.

Top module: `imm_ldst_unit`

## Requirements
- R1: The register index in instruction bits [25:21] (LSB = bit 0) is the target for add and load and the data source for store. The base index is bits [20:16]. The immediate is bits [15:0], sign-extended to 64 bits. Bits [31:26] have no effect.
- R2: Add-immediate (op 0) writes base + sign-extended immediate to the target register. The write-back port shows valid, index and value in the cycle after the acceptance edge.
- R3: A base index of 0 selects a base of zero, even when register 0 holds a non-zero value. This holds for add, load and store alike.
- R4: The effective address is base + sign-extended displacement, modulo 2^64. It is driven on mem_req_addr from the cycle after acceptance.
- R5: Load (op 1) issues a read (mem_req_write = 0). On the edge where mem_rsp_valid is high, it writes {32'h0, mem_rsp_rdata} to the target register. The write-back port shows this in the following cycle, and not before the response.
- R6: Store (op 2) issues a write (mem_req_write = 1) whose mem_req_wdata is the low 32 bits of the source register. It writes no register and raises no write-back.
- R7: insn_ready is high only when no operation is in progress. A request stays valid with stable address, data and direction until mem_req_ready. Exactly one request is made per load or store, and none for add or no-op.
- R8: After reset, insn_ready = 1, mem_req_valid = 0, wb_valid = 0, and every register reads as zero.
- R9: Op code 3 is accepted and has no effect: no register write, no write-back and no memory request.
- R10: rf_fill_en writes rf_fill_data into register rf_fill_idx at the clock edge. When it hits the same register on the same edge as an internal write, the internal write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| insn_valid | input | 1 | Instruction offered |
| insn_ready | output | 1 | Unit idle and taking an instruction |
| insn_op | input | 2 | Operation code (0 add, 1 load, 2 store, 3 no-op) |
| insn_word | input | 32 | Instruction word |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 64 | Effective byte address |
| mem_req_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_rdata | input | 32 | Load data |
| rf_fill_en | input | 1 | External register write enable |
| rf_fill_idx | input | 5 | External register write index |
| rf_fill_data | input | 64 | External register write value |
| wb_valid | output | 1 | A register was written by the unit on the previous edge |
| wb_idx | output | 5 | Index of that register |
| wb_data | output | 64 | Value written |

## Verification
Each result has a fixed due cycle. An add result appears on the write-back port one cycle after its acceptance edge. A load or store request appears one cycle after acceptance and is held through any number of stall cycles. A load result appears one cycle after the response edge. The bench drives and samples on falling edges. It checks each result at exactly its due cycle, and it also checks that nothing shows up earlier: no write-back during response latency, and none at all for stores and no-ops. Register contents are observed through later add-immediate operations with a zero immediate, compared against a bench-side register model.

// File: rtl/imm_ldst_pkg.sv
package imm_ldst_pkg;
  localparam int XLEN   = 64;
  localparam int NREG   = 32;
  localparam int ILEN   = 32;
  localparam int IMMW   = 16;
  localparam int WORDW  = 32;
  localparam int IDXW   = $clog2(NREG);
  localparam int RB_LSB = IMMW;
  localparam int RT_LSB = IMMW + IDXW;

  typedef enum logic [1:0] {
    OP_ADDI  = 2'd0,
    OP_LOADW = 2'd1,
    OP_STORW = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } state_e;
endpackage

// File: rtl/imm_ldst_decode.sv
module imm_ldst_decode
  import imm_ldst_pkg::*;
#(
  parameter int P_XLEN = XLEN,
  parameter int P_ILEN = ILEN,
  parameter int P_IMMW = IMMW,
  parameter int P_IDXW = IDXW
) (
  input  logic [P_ILEN-1:0] word,
  output logic [P_IDXW-1:0] rt_idx,
  output logic [P_IDXW-1:0] rb_idx,
  output logic [P_XLEN-1:0] imm_sx
);
  localparam int L_RB = P_IMMW;
  localparam int L_RT = P_IMMW + P_IDXW;
  localparam int L_TOP = P_IMMW + 2 * P_IDXW;

  logic [P_IMMW-1:0] imm_raw;
  logic unused_opc;

  always_comb begin
    rt_idx  = word[L_RT +: P_IDXW];
    rb_idx  = word[L_RB +: P_IDXW];
    imm_raw = word[P_IMMW-1:0];
    imm_sx  = {{(P_XLEN-P_IMMW){imm_raw[P_IMMW-1]}}, imm_raw};
  end

  assign unused_opc = ^word[P_ILEN-1:L_TOP];
endmodule

// File: rtl/imm_ldst_regfile.sv
module imm_ldst_regfile
  import imm_ldst_pkg::*;
#(
  parameter int P_XLEN = XLEN,
  parameter int P_NREG = NREG,
  parameter int P_IDXW = IDXW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P_IDXW-1:0] rd_a_idx,
  output logic [P_XLEN-1:0] rd_a_data,
  input  logic [P_IDXW-1:0] rd_b_idx,
  output logic [P_XLEN-1:0] rd_b_data,
  input  logic              wr_int_en,
  input  logic [P_IDXW-1:0] wr_int_idx,
  input  logic [P_XLEN-1:0] wr_int_data,
  input  logic              wr_ext_en,
  input  logic [P_IDXW-1:0] wr_ext_idx,
  input  logic [P_XLEN-1:0] wr_ext_data
);
  logic [P_XLEN-1:0] regs_q [P_NREG];

  for (genvar g = 0; g < P_NREG; g++) begin : g_entry
    logic              hit_int, hit_ext, en;
    logic [P_XLEN-1:0] d;
    always_comb begin
      hit_int = wr_int_en && (wr_int_idx == P_IDXW'(g));
      hit_ext = wr_ext_en && (wr_ext_idx == P_IDXW'(g));
      en      = hit_int || hit_ext;
      d       = hit_int ? wr_int_data : wr_ext_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (en)  regs_q[g] <= d;
    end
  end

  assign rd_a_data = regs_q[rd_a_idx];
  assign rd_b_data = regs_q[rd_b_idx];
endmodule

// File: rtl/imm_ldst_addgen.sv
module imm_ldst_addgen
  import imm_ldst_pkg::*;
#(
  parameter int P_XLEN = XLEN,
  parameter int P_IDXW = IDXW
) (
  input  logic [P_IDXW-1:0] base_idx,
  input  logic [P_XLEN-1:0] base_reg,
  input  logic [P_XLEN-1:0] offset,
  output logic [P_XLEN-1:0] sum
);
  logic [P_XLEN-1:0] base_val;

  always_comb begin
    base_val = (base_idx == '0) ? '0 : base_reg;
    sum      = base_val + offset;
  end
endmodule

// File: rtl/imm_ldst_unit.sv
module imm_ldst_unit
  import imm_ldst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_valid,
  output logic             insn_ready,
  input  logic [1:0]       insn_op,
  input  logic [ILEN-1:0]  insn_word,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [XLEN-1:0]  mem_req_addr,
  output logic [WORDW-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [WORDW-1:0] mem_rsp_rdata,
  input  logic             rf_fill_en,
  input  logic [IDXW-1:0]  rf_fill_idx,
  input  logic [XLEN-1:0]  rf_fill_data,
  output logic             wb_valid,
  output logic [IDXW-1:0]  wb_idx,
  output logic [XLEN-1:0]  wb_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // decode, register read, address/sum
  logic [IDXW-1:0] dec_rt, dec_rb;
  logic [XLEN-1:0] dec_imm, rd_base, rd_src, sum;

  imm_ldst_decode u_decode (
    .word(insn_word), .rt_idx(dec_rt), .rb_idx(dec_rb), .imm_sx(dec_imm)
  );

  logic            rf_we;
  logic [IDXW-1:0] rf_widx;
  logic [XLEN-1:0] rf_wdata;

  imm_ldst_regfile u_rf (
    .clk(clk), .rst_n(rst_n_i),
    .rd_a_idx(dec_rb), .rd_a_data(rd_base),
    .rd_b_idx(dec_rt), .rd_b_data(rd_src),
    .wr_int_en(rf_we), .wr_int_idx(rf_widx), .wr_int_data(rf_wdata),
    .wr_ext_en(rf_fill_en), .wr_ext_idx(rf_fill_idx), .wr_ext_data(rf_fill_data)
  );

  imm_ldst_addgen u_agen (
    .base_idx(dec_rb), .base_reg(rd_base), .offset(dec_imm), .sum(sum)
  );

  logic unused_src_hi;
  assign unused_src_hi = ^rd_src[XLEN-1:WORDW];

  // sequencer state
  state_e           state_q, state_d;
  logic             is_wr_q;
  logic [IDXW-1:0]  rt_q;
  logic [XLEN-1:0]  addr_q;
  logic [WORDW-1:0] wdata_q;
  logic             wbv_q;
  logic [IDXW-1:0]  wbi_q;
  logic [XLEN-1:0]  wbd_q;

  logic accept, op_addi, op_mem, rsp_take;

  always_comb begin
    accept   = insn_valid && (state_q == ST_IDLE);
    op_addi  = (op_e'(insn_op) == OP_ADDI);
    op_mem   = (op_e'(insn_op) == OP_LOADW) || (op_e'(insn_op) == OP_STORW);
    rsp_take = (state_q == ST_RSP) && mem_rsp_valid;

    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept && op_mem) state_d = ST_REQ;
      ST_REQ:  if (mem_req_ready) state_d = is_wr_q ? ST_IDLE : ST_RSP;
      ST_RSP:  if (mem_rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    rf_we    = 1'b0;
    rf_widx  = dec_rt;
    rf_wdata = sum;
    if (accept && op_addi) begin
      rf_we = 1'b1;
    end else if (rsp_take) begin
      rf_we    = 1'b1;
      rf_widx  = rt_q;
      rf_wdata = {{(XLEN-WORDW){1'b0}}, mem_rsp_rdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      wbv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wbv_q   <= rf_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      is_wr_q <= 1'b0;
      rt_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      is_wr_q <= (op_e'(insn_op) == OP_STORW);
      rt_q    <= dec_rt;
      addr_q  <= sum;
      wdata_q <= rd_src[WORDW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wbi_q <= '0;
      wbd_q <= '0;
    end else if (rf_we) begin
      wbi_q <= rf_widx;
      wbd_q <= rf_wdata;
    end
  end

  assign insn_ready    = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_write = is_wr_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign wb_valid      = wbv_q;
  assign wb_idx        = wbi_q;
  assign wb_data       = wbd_q;

  // R7: a stalled request is held unchanged
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
       && $stable(mem_req_write)));

  // R7: no new instruction while a request is outstanding
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_req_valid |-> !insn_ready);

  // R5: a load response produces a zero-extended write-back next cycle
  a_r5_load_wb: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((state_q == ST_RSP) && mem_rsp_valid) |=>
      (wb_valid && (wb_data[XLEN-1:WORDW] == '0)
       && (wb_data[WORDW-1:0] == $past(mem_rsp_rdata))));

  // R6: an accepted store leaves the write-back port idle
  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> !wb_valid);

  // R3: zero base index gives the bare immediate for add
  a_r3_zero_base: assert property (@(posedge clk) disable iff (!rst_n_i)
    (insn_valid && insn_ready && (insn_op == 2'd0) && (insn_word[20:16] == 5'd0)) |=>
      (wb_valid && (wb_data == {{(XLEN-IMMW){$past(insn_word[IMMW-1])}},
                                $past(insn_word[IMMW-1:0])})));

  // R9: no-op produces neither write-back nor request
  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    (insn_valid && insn_ready && (insn_op == 2'd3)) |=> (!wb_valid && !mem_req_valid));
endmodule

// File: tb/imm_ldst_unit_tb.sv
module imm_ldst_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid, insn_ready;
  logic [1:0]  insn_op;
  logic [31:0] insn_word;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        rf_fill_en;
  logic [4:0]  rf_fill_idx;
  logic [63:0] rf_fill_data;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;

  always #4 clk = ~clk;

  imm_ldst_unit u_dut (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [63:0] model_rf [32];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  function automatic logic [31:0] mem_fn(input logic [63:0] a);
    return a[31:0] ^ a[63:32] ^ 32'h9E37_79B9;
  endfunction

  task automatic fill(input logic [4:0] idx, input logic [63:0] val);
    @(negedge clk);
    rf_fill_en = 1'b1; rf_fill_idx = idx; rf_fill_data = val;
    @(posedge clk);
    @(negedge clk);
    rf_fill_en = 1'b0;
    model_rf[idx] = val;
  endtask

  task automatic run(input logic [1:0] op, input logic [4:0] rt, input logic [4:0] ra,
                     input logic [15:0] imm, input int stall, input int lat,
                     input bit collide, input logic [63:0] cval);
    logic [63:0] base, ea;
    logic [31:0] rd, junk;
    base = (ra == 5'd0) ? 64'd0 : model_rf[ra];
    ea   = base + sx(imm);
    junk = $urandom();
    @(negedge clk);
    chk(insn_ready === 1'b1, "R7 ready when idle", {63'd0, insn_ready}, 64'd1);
    insn_valid = 1'b1; insn_op = op; insn_word = {junk[5:0], rt, ra, imm};
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    case (op)
      2'd0: begin
        chk(wb_valid === 1'b1 && wb_idx == rt, "R2 add write-back idx", {59'd0, wb_idx}, {59'd0, rt});
        chk(wb_data === ea, (ra == 0) ? "R3 R1 add zero base" : "R2 R1 add value", wb_data, ea);
        model_rf[rt] = ea;
      end
      2'd3: begin
        chk(!wb_valid && !mem_req_valid, "R9 no-op quiet", {62'd0, wb_valid, mem_req_valid}, 64'd0);
      end
      default: begin
        chk(mem_req_valid === 1'b1, "R7 request issued", {63'd0, mem_req_valid}, 64'd1);
        chk(mem_req_addr === ea, (ra == 0) ? "R3 R4 address zero base" : "R4 address", mem_req_addr, ea);
        chk(mem_req_write === (op == 2'd2), "R5 R6 direction", {63'd0, mem_req_write}, {63'd0, op == 2'd2});
        if (op == 2'd2)
          chk(mem_req_wdata === model_rf[rt][31:0], "R6 store data", {32'd0, mem_req_wdata}, {32'd0, model_rf[rt][31:0]});
        for (int s = 0; s < stall; s++) begin
          @(posedge clk);
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr === ea && !insn_ready, "R7 hold under stall", mem_req_addr, ea);
        end
        mem_req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid, "R7 single request", {63'd0, mem_req_valid}, 64'd0);
        if (op == 2'd2) begin
          chk(!wb_valid && insn_ready, "R6 store no write-back", {62'd0, wb_valid, insn_ready}, 64'd1);
        end else begin
          for (int l = 0; l < lat; l++) begin
            chk(!wb_valid, "R5 no early write-back", {63'd0, wb_valid}, 64'd0);
            @(posedge clk);
            @(negedge clk);
          end
          rd = mem_fn(ea);
          mem_rsp_valid = 1'b1; mem_rsp_rdata = rd;
          if (collide) begin
            rf_fill_en = 1'b1; rf_fill_idx = rt; rf_fill_data = cval;
          end
          @(posedge clk);
          @(negedge clk);
          mem_rsp_valid = 1'b0; rf_fill_en = 1'b0;
          chk(wb_valid && wb_idx == rt, "R5 load write-back idx", {59'd0, wb_idx}, {59'd0, rt});
          chk(wb_data === {32'd0, rd}, "R5 load zero-filled", wb_data, {32'd0, rd});
          model_rf[rt] = {32'd0, rd};
        end
      end
    endcase
  endtask

  // read register k through an add with zero immediate
  task automatic peek(input logic [4:0] k, input string tag);
    logic [63:0] exp;
    exp = (k == 0) ? 64'd0 : model_rf[k];
    run(2'd0, 5'd31, k, 16'd0, 0, 0, 1'b0, 64'd0);
    if (k != 0) chk(model_rf[31] === exp, tag, model_rf[31], exp);
  endtask

  initial begin
    void'($urandom(32'h0005EED5));
    for (int i = 0; i < 32; i++) model_rf[i] = 64'd0;
    rst_n = 1'b0; insn_valid = 1'b0; insn_op = 2'd0; insn_word = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    rf_fill_en = 1'b0; rf_fill_idx = '0; rf_fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(insn_ready && !mem_req_valid && !wb_valid, "R8 reset outputs",
        {61'd0, insn_ready, mem_req_valid, wb_valid}, 64'd4);
    peek(5'd7, "R8 register zero after reset");
    peek(5'd30, "R8 register zero after reset");

    // R10 fill and R3 literal zero base
    fill(5'd0, 64'hDEAD_BEEF_0000_1234);
    run(2'd0, 5'd4, 5'd0, 16'h8001, 0, 0, 1'b0, 64'd0);
    run(2'd1, 5'd5, 5'd0, 16'h0040, 1, 1, 1'b0, 64'd0);
    fill(5'd3, 64'h0123_4567_89AB_CDEF);
    peek(5'd3, "R10 fill visible");
    // R4 wrap-around and negative displacement
    fill(5'd8, 64'hFFFF_FFFF_FFFF_FFF0);
    run(2'd1, 5'd9, 5'd8, 16'h0020, 0, 2, 1'b0, 64'd0);
    run(2'd2, 5'd3, 5'd8, 16'hFFF0, 2, 0, 1'b0, 64'd0);
    run(2'd0, 5'd10, 5'd3, 16'hFFFF, 0, 0, 1'b0, 64'd0);
    // R6 store takes only low half; R9 no-op
    run(2'd2, 5'd3, 5'd0, 16'h7FFC, 0, 0, 1'b0, 64'd0);
    run(2'd3, 5'd12, 5'd3, 16'h1111, 0, 0, 1'b0, 64'd0);
    peek(5'd12, "R9 no-op left register");
    // R10 collision: internal load write wins
    run(2'd1, 5'd14, 5'd3, 16'h0010, 0, 1, 1'b1, 64'h5555_AAAA_5555_AAAA);
    peek(5'd14, "R10 internal write wins");

    for (int n = 0; n < 200; n++) begin
      logic [31:0] r;
      r = $urandom();
      if (r[3:0] == 4'd0) fill(5'($urandom()), {$urandom(), $urandom()});
      else run(r[5:4], 5'($urandom()), (r[8:6] == 0) ? 5'd0 : 5'($urandom()),
               16'($urandom()), int'(r[10:9]) % 3, int'(r[12:11]) % 3,
               r[13] && r[14], {$urandom(), $urandom()});
    end
    for (int k = 1; k < 31; k += 3) peek(5'(k), "R1 R2 register model match");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule